// File: doc/BRIEF.md
# Gated Continuous-Scan Queue Sequencer

This block walks a contiguous range of conversion command indices for as long as an external gate input stays high. For each index it raises a conversion request toward a converter and holds it, with the index, until the converter returns a one-cycle done pulse. The gate and the enable are looked at only when a conversion finishes. The block then decides whether to move to the next index, wrap back to the start of the range, or stop. The range start and end come from configuration inputs and may describe any queue of 1 to DEPTH entries.

Three sticky status bits report what happened. The completion bit is set whenever the final index of the range finishes. The overrun bit is set when the range finishes again before software has acknowledged the earlier completion. The incomplete bit is set when the gate was found closed before the range was finished. A register keeps the index of the most recently finished command, so software can tell which results are valid. Software clears each status bit with its own write-one-to-clear strobe.

Top module: `gate_scan_seq`

## Requirements
- R1: After reset the request output is low, all three status bits are 0 and the last-finished valid bit is 0.
- R2: In idle with both enable and gate high, the request rises on the next cycle with the command index equal to the range start. While the request is high and no done arrives, the request and the index hold.
- R3: When a done is taken for an index other than the range end, with enable and gate high, the request stays high and the index becomes the old index plus one on the next cycle.
- R4: When a done is taken for the range end index with enable and gate high, the completion bit is set and the next index is the range start.
- R5: When the range end finishes while the completion bit is already 1, the overrun bit is set as well.
- R6: When a done is taken with the gate low, enable high and the index not at the range end, the sequencer goes idle (request low) and sets the incomplete bit. If the index was the range end, only completion is reported.
- R7: After a stop caused by the gate, the next start always begins at the range start index.
- R8: The gate is looked at only in the cycle a done is taken. A gate low period that lies wholly inside one conversion has no effect.
- R9: On every taken done, the last-finished pointer takes the index that finished and the valid bit becomes 1.
- R10: Each status bit stays set until its clear strobe is high at a clock edge. When a set and a clear fall in the same cycle, the bit ends up set.
- R11: When a done is taken with enable low, the sequencer goes idle without setting the incomplete bit, whatever the gate level. Status bits are kept.
- R12: With a one-entry range (start equals end), every done sets completion, and a second done sets overrun.
- R13: A done pulse while idle changes neither the status bits nor the last-finished pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Scan mode enable |
| gate | input | 1 | External gate level |
| q_first | input | IDX_W | First command index of the range |
| q_last | input | IDX_W | Last command index of the range (not below q_first) |
| clr_cmp | input | 1 | Clear strobe for the completion bit |
| clr_pause | input | 1 | Clear strobe for the incomplete bit |
| clr_ovr | input | 1 | Clear strobe for the overrun bit |
| conv_req | output | 1 | Conversion request, held until done |
| conv_cmd | output | IDX_W | Command index of the current request |
| conv_done | input | 1 | One-cycle conversion done pulse |
| flag_cmp | output | 1 | Sticky completion bit |
| flag_pause | output | 1 | Sticky incomplete bit |
| flag_ovr | output | 1 | Sticky overrun bit |
| last_done_ptr | output | IDX_W | Index of the most recently finished command |
| last_valid | output | 1 | Last-finished pointer holds a real index |

## Verification
The bench builds the block with DEPTH of 64 and set-priority clearing. This makes a full 64-entry range reachable, including a wrap from index 63 back to 0, along with short mid-array ranges and a one-entry range. Random gate, enable, clear and converter latency patterns run over several ranges against a cycle-level reference. Directed cases then hit the set-versus-clear collision, a gate glitch shorter than a conversion, disable combined with gate closure, and a done pulse while idle.

// File: rtl/gss_pkg.sv
package gss_pkg;
   typedef enum logic [0:0] {
      GSS_IDLE = 1'b0,
      GSS_CONV = 1'b1
   } gss_state_e;

   localparam int unsigned GSS_NFLAG = 3;
   localparam int unsigned FLG_CMP   = 0;
   localparam int unsigned FLG_PAUSE = 1;
   localparam int unsigned FLG_OVR   = 2;
endpackage

// File: rtl/gss_ptr.sv
module gss_ptr #(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_first,
   input  logic             advance,
   input  logic [IDX_W-1:0] q_first,
   input  logic [IDX_W-1:0] q_last,
   output logic [IDX_W-1:0] ptr,
   output logic             at_end
);
   logic [IDX_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_first) begin
         ptr_q <= q_first;
      end else if (advance) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr    = ptr_q;
   assign at_end = (ptr_q == q_last);
endmodule

// File: rtl/gss_flags.sv
module gss_flags #(
   parameter int unsigned NFLAG    = 3,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] flags
);
   if (NFLAG < 1) begin : g_bad_n
      $error("gss_flags: NFLAG must be at least 1");
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_bit
      logic bit_q;
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= set_i[i] | (bit_q & ~clr_i[i]);
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q | set_i[i]) & ~clr_i[i];
         end
      end
      assign flags[i] = bit_q;
   end
endmodule

// File: rtl/gss_last.sv
module gss_last #(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] last_ptr,
   output logic             last_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ptr   <= '0;
         last_valid <= 1'b0;
      end else if (capture) begin
         last_ptr   <= idx;
         last_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/gss_ctrl.sv
module gss_ctrl
   import gss_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic scan_en,
   input  logic gate,
   input  logic conv_done,
   input  logic at_end,
   input  logic cmp_flag,
   output logic conv_req,
   output logic load_first,
   output logic advance,
   output logic capture,
   output logic set_cmp,
   output logic set_pause,
   output logic set_ovr
);
   gss_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GSS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d    = state_q;
      load_first = 1'b0;
      advance    = 1'b0;
      capture    = 1'b0;
      set_cmp    = 1'b0;
      set_pause  = 1'b0;
      set_ovr    = 1'b0;
      unique case (state_q)
         GSS_IDLE: begin
            if (scan_en && gate) begin
               state_d    = GSS_CONV;
               load_first = 1'b1;
            end
         end
         GSS_CONV: begin
            if (conv_done) begin
               capture = 1'b1;
               set_cmp = at_end;
               set_ovr = at_end && cmp_flag;
               if (!scan_en) begin
                  state_d = GSS_IDLE;
               end else if (!gate) begin
                  state_d   = GSS_IDLE;
                  set_pause = !at_end;
               end else if (at_end) begin
                  load_first = 1'b1;
               end else begin
                  advance = 1'b1;
               end
            end
         end
         default: state_d = GSS_IDLE;
      endcase
   end

   assign conv_req = (state_q == GSS_CONV);
endmodule

// File: rtl/gate_scan_seq.sv
module gate_scan_seq
   import gss_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter bit          SET_WINS = 1'b1,
   localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_en,
   input  logic             gate,
   input  logic [IDX_W-1:0] q_first,
   input  logic [IDX_W-1:0] q_last,
   input  logic             clr_cmp,
   input  logic             clr_pause,
   input  logic             clr_ovr,
   output logic             conv_req,
   output logic [IDX_W-1:0] conv_cmd,
   input  logic             conv_done,
   output logic             flag_cmp,
   output logic             flag_pause,
   output logic             flag_ovr,
   output logic [IDX_W-1:0] last_done_ptr,
   output logic             last_valid
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("gate_scan_seq: DEPTH must be a power of two, at least 2");
   end

   logic                 load_first, advance, capture, at_end;
   logic                 set_cmp, set_pause, set_ovr;
   logic [GSS_NFLAG-1:0] flag_set, flag_clr, flag_q;

   gss_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_en    (scan_en),
      .gate       (gate),
      .conv_done  (conv_done),
      .at_end     (at_end),
      .cmp_flag   (flag_q[FLG_CMP]),
      .conv_req   (conv_req),
      .load_first (load_first),
      .advance    (advance),
      .capture    (capture),
      .set_cmp    (set_cmp),
      .set_pause  (set_pause),
      .set_ovr    (set_ovr)
   );

   gss_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_first (load_first),
      .advance    (advance),
      .q_first    (q_first),
      .q_last     (q_last),
      .ptr        (conv_cmd),
      .at_end     (at_end)
   );

   always_comb begin
      flag_set            = '0;
      flag_clr            = '0;
      flag_set[FLG_CMP]   = set_cmp;
      flag_set[FLG_PAUSE] = set_pause;
      flag_set[FLG_OVR]   = set_ovr;
      flag_clr[FLG_CMP]   = clr_cmp;
      flag_clr[FLG_PAUSE] = clr_pause;
      flag_clr[FLG_OVR]   = clr_ovr;
   end

   gss_flags #(.NFLAG(GSS_NFLAG), .SET_WINS(SET_WINS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (flag_clr),
      .flags (flag_q)
   );

   assign flag_cmp   = flag_q[FLG_CMP];
   assign flag_pause = flag_q[FLG_PAUSE];
   assign flag_ovr   = flag_q[FLG_OVR];

   gss_last #(.IDX_W(IDX_W)) u_last (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (capture),
      .idx        (conv_cmd),
      .last_ptr   (last_done_ptr),
      .last_valid (last_valid)
   );
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
   parameter int unsigned IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scan_en,
   input logic             gate,
   input logic [IDX_W-1:0] q_first,
   input logic [IDX_W-1:0] q_last,
   input logic             clr_cmp,
   input logic             clr_pause,
   input logic             clr_ovr,
   input logic             conv_req,
   input logic [IDX_W-1:0] conv_cmd,
   input logic             conv_done,
   input logic             flag_cmp,
   input logic             flag_pause,
   input logic             flag_ovr
);
   // R2: request and index hold until done
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> (conv_req && $stable(conv_cmd)));

   // R3: step to next index inside the range
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && conv_done && scan_en && gate && conv_cmd != q_last)
      |=> (conv_req && conv_cmd == IDX_W'($past(conv_cmd) + 1'b1)));

   // R4: index stays inside the configured range
   assert_cmd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (conv_cmd >= q_first && conv_cmd <= q_last));

   // R5: overrun only follows an unacknowledged completion
   assert_ovr_after_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_ovr) |-> $past(flag_cmp));

   // R6: incomplete bit only rises after a done seen with the gate low
   assert_pause_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_pause) |-> $past(conv_done && !gate && conv_req));

   // R10: status bits are sticky without a clear
   assert_cmp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_cmp && !clr_cmp) |=> flag_cmp);
   assert_pause_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_pause && !clr_pause) |=> flag_pause);
   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ovr && !clr_ovr) |=> flag_ovr);
endmodule

bind gate_scan_seq gss_checker #(.IDX_W(IDX_W)) u_gss_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .scan_en    (scan_en),
   .gate       (gate),
   .q_first    (q_first),
   .q_last     (q_last),
   .clr_cmp    (clr_cmp),
   .clr_pause  (clr_pause),
   .clr_ovr    (clr_ovr),
   .conv_req   (conv_req),
   .conv_cmd   (conv_cmd),
   .conv_done  (conv_done),
   .flag_cmp   (flag_cmp),
   .flag_pause (flag_pause),
   .flag_ovr   (flag_ovr)
);

// File: tb/gate_scan_seq_bench.sv
module gate_scan_seq_bench;
   localparam int unsigned DEPTH = 64;
   localparam int unsigned IW    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0, gate = 1'b0;
   logic [IW-1:0] q_first = '0, q_last = '0;
   logic          clr_cmp = 1'b0, clr_pause = 1'b0, clr_ovr = 1'b0;
   logic          conv_done = 1'b0;
   logic          conv_req, flag_cmp, flag_pause, flag_ovr, last_valid;
   logic [IW-1:0] conv_cmd, last_done_ptr;

   int checks = 0, errors = 0, cyc = 0;
   bit cmp_on = 1'b0, conv_auto = 1'b1;
   int fixed_lat = 0, lat = 2, cnt = 0;

   // reference state
   bit            m_run, m_cmp, m_pause, m_ovr, m_lv;
   logic [IW-1:0] m_ptr, m_last;

   always #4 clk = ~clk;

   gate_scan_seq #(.DEPTH(DEPTH)) u_gate_scan_seq (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .gate(gate),
      .q_first(q_first), .q_last(q_last),
      .clr_cmp(clr_cmp), .clr_pause(clr_pause), .clr_ovr(clr_ovr),
      .conv_req(conv_req), .conv_cmd(conv_cmd), .conv_done(conv_done),
      .flag_cmp(flag_cmp), .flag_pause(flag_pause), .flag_ovr(flag_ovr),
      .last_done_ptr(last_done_ptr), .last_valid(last_valid)
   );

   always @(posedge clk) begin
      bit endq, sc, sp, so;
      sc = 0; sp = 0; so = 0;
      if (!rst_n) begin
         m_run = 0; m_cmp = 0; m_pause = 0; m_ovr = 0; m_lv = 0;
         m_ptr = '0; m_last = '0;
      end else begin
         if (!m_run) begin
            if (scan_en && gate) begin m_run = 1; m_ptr = q_first; end
         end else if (conv_done) begin
            endq = (m_ptr == q_last);
            m_last = m_ptr; m_lv = 1;
            sc = endq; so = endq && m_cmp;
            if (!scan_en) m_run = 0;
            else if (!gate) begin m_run = 0; sp = !endq; end
            else m_ptr = endq ? q_first : m_ptr + 1'b1;
         end
         m_cmp   = sc | (m_cmp & ~clr_cmp);
         m_pause = sp | (m_pause & ~clr_pause);
         m_ovr   = so | (m_ovr & ~clr_ovr);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (cmp_on) begin
         chk(conv_req === m_run, "R2 request level", conv_req, m_run);
         if (m_run) chk(conv_cmd === m_ptr, "R3 command index", conv_cmd, m_ptr);
         chk(flag_cmp === m_cmp, "R4 completion bit", flag_cmp, m_cmp);
         chk(flag_ovr === m_ovr, "R5 overrun bit", flag_ovr, m_ovr);
         chk(flag_pause === m_pause, "R6 incomplete bit", flag_pause, m_pause);
         chk(last_valid === m_lv, "R9 last valid", last_valid, m_lv);
         if (m_lv) chk(last_done_ptr === m_last, "R9 last pointer", last_done_ptr, m_last);
      end
      if (conv_auto) begin
         if (conv_req && !conv_done) begin
            cnt++;
            if (cnt >= lat) begin
               conv_done = 1'b1;
               cnt = 0;
               lat = (fixed_lat != 0) ? fixed_lat : 1 + int'($urandom % 4);
            end
         end else begin
            conv_done = 1'b0;
            if (!conv_req) cnt = 0;
         end
      end
   endtask

   task automatic wait_idle();
      scan_en = 1'b0;
      tick();
      while (conv_req) tick();
      tick();
   endtask

   task automatic wait_dones(input int n);
      int left = n;
      while (left > 0) begin
         tick();
         if (conv_done) left--;
      end
   endtask

   task automatic clear_all();
      clr_cmp = 1; clr_pause = 1; clr_ovr = 1;
      tick();
      clr_cmp = 0; clr_pause = 0; clr_ovr = 0;
   endtask

   task automatic set_lat(input int l);
      fixed_lat = l; lat = l; cnt = 0;
   endtask

   task automatic random_run(input int f, input int l, input int n);
      int hold = 0;
      q_first = IW'(f); q_last = IW'(l);
      set_lat(0);
      tick();
      scan_en = 1; gate = 1;
      for (int i = 0; i < n; i++) begin
         if (hold == 0) begin
            gate = ($urandom % 100) < 85;
            hold = 1 + int'($urandom % 12);
         end else hold--;
         scan_en   = ($urandom % 100) < 97;
         clr_cmp   = ($urandom % 100) < 6;
         clr_pause = ($urandom % 100) < 6;
         clr_ovr   = ($urandom % 100) < 6;
         tick();
      end
      clr_cmp = 0; clr_pause = 0; clr_ovr = 0;
      wait_idle();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [IW-1:0] keep_ptr;
      void'($urandom(32'd1357));
      repeat (3) tick();
      // R1: reset state
      chk(conv_req === 1'b0, "R1 request after reset", conv_req, 0);
      chk({flag_cmp, flag_pause, flag_ovr} === 3'b000, "R1 flags after reset",
          {flag_cmp, flag_pause, flag_ovr}, 0);
      chk(last_valid === 1'b0, "R1 last valid after reset", last_valid, 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      tick();

      // random phases over several ranges (full 0..63 wraps at 63)
      random_run(0, 63, 900);
      random_run(5, 9, 600);
      random_run(17, 17, 300);
      random_run(60, 63, 500);

      // R12: one-entry range completes and then overruns
      clear_all();
      q_first = 6'd17; q_last = 6'd17; set_lat(1);
      tick();
      scan_en = 1; gate = 1;
      wait_dones(2);
      tick();
      chk(flag_cmp && flag_ovr, "R12 one-entry completion and overrun",
          {flag_cmp, flag_ovr}, 3);
      chk(conv_cmd === 6'd17, "R12 index stays at single entry", conv_cmd, 17);

      // R10: clear strobes drop sticky bits
      wait_idle();
      clear_all();
      chk({flag_cmp, flag_pause, flag_ovr} === 3'b000, "R10 clear strobes",
          {flag_cmp, flag_pause, flag_ovr}, 0);

      // R10: set wins over a simultaneous clear
      clr_cmp = 1;
      scan_en = 1; gate = 1;
      wait_dones(1);
      tick();
      chk(flag_cmp === 1'b1, "R10 set beats clear", flag_cmp, 1);
      clr_cmp = 0;
      wait_idle();
      clear_all();

      // R6/R7: gate closes mid range, restart from first index
      q_first = 6'd5; q_last = 6'd9; set_lat(2);
      tick();
      scan_en = 1; gate = 1;
      wait_dones(2);
      gate = 0;
      tick();
      chk(!conv_req && flag_pause, "R6 stop with incomplete bit",
          {conv_req, flag_pause}, 1);
      chk(last_done_ptr === 6'd6, "R9 last pointer after stop", last_done_ptr, 6);
      gate = 1;
      tick();
      chk(conv_req && conv_cmd === 6'd5, "R7 restart at range start", conv_cmd, 5);
      wait_idle();
      clear_all();

      // R8: short gate glitch inside one conversion is missed
      q_first = 6'd0; q_last = 6'd63; set_lat(4);
      tick();
      scan_en = 1; gate = 1;
      wait_dones(1);
      tick();
      gate = 0;
      tick();
      gate = 1;
      wait_dones(1);
      tick();
      chk(conv_req && !flag_pause, "R8 glitch ignored", {conv_req, flag_pause}, 2);

      // R11: disable wins over gate closure, no incomplete bit
      set_lat(2);
      wait_dones(2);
      scan_en = 0; gate = 0;
      tick();
      chk(!conv_req && !flag_pause, "R11 disable goes idle quietly",
          {conv_req, flag_pause}, 0);

      // R13: done while idle is ignored
      tick();
      keep_ptr = last_done_ptr;
      conv_auto = 0;
      conv_done = 1;
      tick();
      conv_done = 0;
      tick();
      chk(last_done_ptr === keep_ptr && !conv_req && !flag_pause && !flag_cmp,
          "R13 idle done ignored", last_done_ptr, keep_ptr);
      conv_auto = 1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule